// File: doc/BRIEF.md
# Cartridge bank-switching address translator

This block sits between a CPU, a picture processor and the program and pattern memories of a cartridge. The CPU programs it by writing to a select/data register pair and a mirroring register. The block then turns the window bits of a CPU program fetch into a program bank number, and the slot bits of a picture-processor pattern fetch into a pattern bank number. Both translations are purely combinational from the current register state.

Program space is seen as four 8 KiB windows. Three of them follow bank registers, and the top window is pinned to the last installed bank. Pattern space is seen as eight 1 KiB slots. The lower four slots come either from two 2 KiB pairs or, in full-1 KiB mode, from four independent registers. A half-invert bit exchanges the lower and upper halves of pattern space.

The write port is a plain strobe with no back-pressure: every strobed cycle is accepted and takes effect at the next clock edge. The caller passes only the decoded address bits the block uses. Bank counts must be powers of two between 2 and 256.

Top module: `bank_xlate`

## Requirements
- R1: A strobed write with page 3'b100 and even parity loads the register index from data[3:0], half-invert from data[7], program swap from data[6] and full-1 KiB mode from data[5]. All take effect from the next clock edge.
- R2: A strobed write with page 3'b100 and odd parity stores data into the register named by the current index when that index is 0–9 or 15. For indices 10–14 no bank output changes. Without a strobe no register changes.
- R3: With program swap clear, program window 0 follows register 6, window 1 follows register 7 and window 2 follows register 15.
- R4: With program swap set, windows 0 and 2 exchange registers 6 and 15. Window 1 is unaffected.
- R5: Window 3 always yields PRG_BANKS-1. Every program bank output is the register value modulo PRG_BANKS, and every pattern bank output is the register value modulo CHR_BANKS.
- R6: When half-invert is set, the effective pattern slot is the slot input XOR 4.
- R7: With full-1 KiB mode clear, effective slots 0 and 1 give register 0 with bit 0 forced to 0 and to 1 respectively. Effective slots 2 and 3 do the same with register 1.
- R8: With full-1 KiB mode set, effective slots 0, 1, 2 and 3 give registers 0, 8, 1 and 9.
- R9: Effective slots 4, 5, 6 and 7 give registers 2, 3, 4 and 5, whatever the mode.
- R10: A strobed write with page 3'b101 and even parity sets mirror_h from data[0] (0 vertical, 1 horizontal). Odd-parity writes to that page leave mirror_h unchanged.
- R11: Reset clears every bank register, the index and all mode bits, and selects vertical mirroring (mirror_h = 0).
- R12: Writes to any page other than 3'b100 and 3'b101 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Write strobe, one write per cycle |
| cpu_wr_page | input | 3 | CPU write address bits 15:13 |
| cpu_wr_odd | input | 1 | CPU write address bit 0 |
| cpu_wr_data | input | 8 | CPU write data |
| prg_win | input | 2 | CPU fetch address bits 14:13 (program window) |
| prg_bank | output | $clog2(PRG_BANKS) | Translated program bank |
| chr_slot | input | 3 | Picture-processor address bits 12:10 (pattern slot) |
| chr_bank | output | $clog2(CHR_BANKS) | Translated pattern bank |
| mirror_h | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The bench builds the block with PRG_BANKS = 16 and CHR_BANKS = 128. At these sizes a full byte written to a bank register exceeds the installed range, so the modulo behaviour and the pinned top window (15 rather than the default 31) are both exercised. Random bytes regularly set the high bits that must be discarded. At the default sizes, program truncation would only show in the three top bits, and pattern truncation would not show at all.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam logic [2:0] PAGE_BANK   = 3'b100;
  localparam logic [2:0] PAGE_MIRROR = 3'b101;

  typedef struct packed {
    logic half_inv;
    logic prg_swap;
    logic full_1k;
  } bx_mode_t;
endpackage

// File: rtl/bx_regfile.sv
module bx_regfile
  import bx_pkg::*;
#(
  parameter int PRG_W = 5,
  parameter int CHR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_page,
  input  logic                       wr_odd,
  input  logic [7:0]                 wr_data,
  output bx_mode_t                   mode,
  output logic [3:0]                 sel_idx,
  output logic [2:0][PRG_W-1:0]      prg_regs,
  output logic [7:0][CHR_W-1:0]      chr_regs,
  output logic                       mirror_h
);
  logic sel_wr, data_wr, mir_wr;

  assign sel_wr  = wr_en && (wr_page == PAGE_BANK)   && !wr_odd;
  assign data_wr = wr_en && (wr_page == PAGE_BANK)   &&  wr_odd;
  assign mir_wr  = wr_en && (wr_page == PAGE_MIRROR) && !wr_odd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_idx <= '0;
      mode    <= '0;
    end else if (sel_wr) begin
      sel_idx       <= wr_data[3:0];
      mode.half_inv <= wr_data[7];
      mode.prg_swap <= wr_data[6];
      mode.full_1k  <= wr_data[5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mirror_h <= 1'b0;
    else if (mir_wr) mirror_h <= wr_data[0];
  end

  // Program registers in order 6, 7, 15.
  for (genvar k = 0; k < 3; k++) begin : g_prg
    localparam logic [3:0] IDX = (k == 0) ? 4'd6 : (k == 1) ? 4'd7 : 4'd15;
    logic [PRG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         q <= '0;
      else if (data_wr && sel_idx == IDX) q <= wr_data[PRG_W-1:0];
    end
    assign prg_regs[k] = q;
  end

  // Pattern registers in order 0,1,2,3,4,5,8,9.
  for (genvar k = 0; k < 8; k++) begin : g_chr
    localparam logic [3:0] IDX = (k < 6) ? 4'(k) : 4'(k + 2);
    logic [CHR_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         q <= '0;
      else if (data_wr && sel_idx == IDX) q <= wr_data[CHR_W-1:0];
    end
    assign chr_regs[k] = q;
  end
endmodule

// File: rtl/bx_prg_map.sv
module bx_prg_map #(
  parameter int PRG_BANKS = 32,
  localparam int PRG_W = $clog2(PRG_BANKS)
) (
  input  logic [1:0]            win,
  input  logic                  swap,
  input  logic [2:0][PRG_W-1:0] regs,
  output logic [PRG_W-1:0]      bank
);
  localparam logic [PRG_W-1:0] LAST = PRG_W'(PRG_BANKS - 1);

  always_comb begin
    unique case (win)
      2'd0:    bank = swap ? regs[2] : regs[0];
      2'd1:    bank = regs[1];
      2'd2:    bank = swap ? regs[0] : regs[2];
      default: bank = LAST;
    endcase
  end
endmodule

// File: rtl/bx_chr_map.sv
module bx_chr_map #(
  parameter int CHR_W = 8
) (
  input  logic [2:0]            slot,
  input  logic                  half_inv,
  input  logic                  full_1k,
  input  logic [7:0][CHR_W-1:0] regs,
  output logic [CHR_W-1:0]      bank
);
  logic [2:0] eff;
  assign eff = slot ^ {half_inv, 2'b00};

  always_comb begin
    unique case (eff)
      3'd0:    bank = full_1k ? regs[0] : {regs[0][CHR_W-1:1], 1'b0};
      3'd1:    bank = full_1k ? regs[6] : {regs[0][CHR_W-1:1], 1'b1};
      3'd2:    bank = full_1k ? regs[1] : {regs[1][CHR_W-1:1], 1'b0};
      3'd3:    bank = full_1k ? regs[7] : {regs[1][CHR_W-1:1], 1'b1};
      3'd4:    bank = regs[2];
      3'd5:    bank = regs[3];
      3'd6:    bank = regs[4];
      default: bank = regs[5];
    endcase
  end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bx_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter int CHR_BANKS = 256,
  localparam int PRG_W = $clog2(PRG_BANKS),
  localparam int CHR_W = $clog2(CHR_BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [2:0]       cpu_wr_page,
  input  logic             cpu_wr_odd,
  input  logic [7:0]       cpu_wr_data,
  input  logic [1:0]       prg_win,
  output logic [PRG_W-1:0] prg_bank,
  input  logic [2:0]       chr_slot,
  output logic [CHR_W-1:0] chr_bank,
  output logic             mirror_h
);
  bx_mode_t                   mode;
  logic [3:0]                 sel_idx;
  logic [2:0][PRG_W-1:0]      prg_regs;
  logic [7:0][CHR_W-1:0]      chr_regs;

  bx_regfile #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cpu_wr),
    .wr_page  (cpu_wr_page),
    .wr_odd   (cpu_wr_odd),
    .wr_data  (cpu_wr_data),
    .mode     (mode),
    .sel_idx  (sel_idx),
    .prg_regs (prg_regs),
    .chr_regs (chr_regs),
    .mirror_h (mirror_h)
  );

  bx_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .win  (prg_win),
    .swap (mode.prg_swap),
    .regs (prg_regs),
    .bank (prg_bank)
  );

  bx_chr_map #(.CHR_W(CHR_W)) u_chr (
    .slot     (chr_slot),
    .half_inv (mode.half_inv),
    .full_1k  (mode.full_1k),
    .regs     (chr_regs),
    .bank     (chr_bank)
  );
endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk
  import bx_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter int PRG_W = 5,
  parameter int CHR_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_wr,
  input logic [2:0]            cpu_wr_page,
  input logic                  cpu_wr_odd,
  input logic [1:0]            prg_win,
  input logic [PRG_W-1:0]      prg_bank,
  input logic [2:0]            chr_slot,
  input logic [CHR_W-1:0]      chr_bank,
  input logic                  mirror_h,
  input bx_mode_t              mode,
  input logic [3:0]            sel_idx,
  input logic [2:0][PRG_W-1:0] prg_regs,
  input logic [7:0][CHR_W-1:0] chr_regs
);
  logic [2:0] eff;
  assign eff = chr_slot ^ {mode.half_inv, 2'b00};

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ($stable(prg_regs) && $stable(chr_regs)));

  p_bad_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_wr_page == PAGE_BANK && cpu_wr_odd && sel_idx >= 4'd10 && sel_idx <= 4'd14)
    |=> ($stable(prg_regs) && $stable(chr_regs)));

  p_swap_win0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_win == 2'd0) |-> (prg_bank == (mode.prg_swap ? prg_regs[2] : prg_regs[0])));

  p_last_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_win == 2'd3) |-> (prg_bank == PRG_W'(PRG_BANKS - 1)));

  p_pair_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.full_1k && !eff[2]) |-> (chr_bank[0] == eff[0]));

  p_upper_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eff == 3'd6) |-> (chr_bank == chr_regs[4]));

  p_mirror_odd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_wr_page == PAGE_MIRROR && cpu_wr_odd) |=> $stable(mirror_h));
endmodule

bind bank_xlate bank_xlate_chk #(
  .PRG_BANKS (PRG_BANKS),
  .PRG_W     (PRG_W),
  .CHR_W     (CHR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_wr      (cpu_wr),
  .cpu_wr_page (cpu_wr_page),
  .cpu_wr_odd  (cpu_wr_odd),
  .prg_win     (prg_win),
  .prg_bank    (prg_bank),
  .chr_slot    (chr_slot),
  .chr_bank    (chr_bank),
  .mirror_h    (mirror_h),
  .mode        (mode),
  .sel_idx     (sel_idx),
  .prg_regs    (prg_regs),
  .chr_regs    (chr_regs)
);

// File: tb/bank_xlate_tb.sv
`timescale 1ns/1ps
module bank_xlate_tb;
  localparam int PB = 16;
  localparam int CB = 128;
  localparam int PW = $clog2(PB);
  localparam int CW = $clog2(CB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [2:0]    cpu_wr_page = '0;
  logic          cpu_wr_odd = 1'b0;
  logic [7:0]    cpu_wr_data = '0;
  logic [1:0]    prg_win = '0;
  logic [PW-1:0] prg_bank;
  logic [2:0]    chr_slot = '0;
  logic [CW-1:0] chr_bank;
  logic          mirror_h;

  int n_chk = 0;
  int n_bad = 0;

  // Bench model
  logic [7:0] m_reg [16];
  logic [3:0] m_sel;
  logic       m_inv, m_swp, m_f1k, m_mir;

  always #4 clk = ~clk;

  bank_xlate #(.PRG_BANKS(PB), .CHR_BANKS(CB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wr_page(cpu_wr_page),
    .cpu_wr_odd(cpu_wr_odd), .cpu_wr_data(cpu_wr_data), .prg_win(prg_win),
    .prg_bank(prg_bank), .chr_slot(chr_slot), .chr_bank(chr_bank),
    .mirror_h(mirror_h)
  );

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    m_sel = '0; m_inv = 0; m_swp = 0; m_f1k = 0; m_mir = 0;
  endtask

  task automatic model_write(input logic [2:0] pg, input logic odd, input logic [7:0] d);
    if (pg == 3'b100) begin
      if (!odd) begin
        m_sel = d[3:0]; m_inv = d[7]; m_swp = d[6]; m_f1k = d[5];
      end else if (m_sel < 4'd10 || m_sel == 4'd15) begin
        m_reg[m_sel] = d;
      end
    end else if (pg == 3'b101 && !odd) begin
      m_mir = d[0];
    end
  endtask

  function automatic int exp_prg(input int w);
    int v;
    case (w)
      0: v = m_swp ? m_reg[15] : m_reg[6];
      1: v = m_reg[7];
      2: v = m_swp ? m_reg[6] : m_reg[15];
      default: v = PB - 1;
    endcase
    return v % PB;
  endfunction

  function automatic int exp_chr(input int s);
    int e, v;
    e = m_inv ? (s ^ 4) : s;
    case (e)
      0: v = m_f1k ? m_reg[0] : (m_reg[0] & 8'hFE);
      1: v = m_f1k ? m_reg[8] : (m_reg[0] | 8'h01);
      2: v = m_f1k ? m_reg[1] : (m_reg[1] & 8'hFE);
      3: v = m_f1k ? m_reg[9] : (m_reg[1] | 8'h01);
      default: v = m_reg[e - 2];
    endcase
    return v % CB;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Called just after a negedge: sweep every window and slot.
  task automatic check_all(input string tag);
    for (int w = 0; w < 4; w++) begin
      prg_win = 2'(w); #0.2;
      check(tag, $sformatf("prg window %0d", w), int'(prg_bank), exp_prg(w));
    end
    for (int s = 0; s < 8; s++) begin
      chr_slot = 3'(s); #0.2;
      check(tag, $sformatf("chr slot %0d", s), int'(chr_bank), exp_chr(s));
    end
    check(tag, "mirror", int'(mirror_h), int'(m_mir));
  endtask

  task automatic wr(input logic [2:0] pg, input logic odd, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wr_page = pg; cpu_wr_odd = odd; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr = 1'b0;
    model_write(pg, odd, d);
  endtask

  task automatic set_reg(input logic [3:0] idx, input logic [7:0] d, input logic [2:0] modes);
    wr(3'b100, 1'b0, {modes, 1'b0, idx});
    wr(3'b100, 1'b1, d);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R11 reset");
    check("R11", "reset top window", int'(prg_bank), PB - 1);

    // Directed: one-cycle latency of a write (R1 select then R2 data)
    @(negedge clk);
    cpu_wr = 1; cpu_wr_page = 3'b100; cpu_wr_odd = 0; cpu_wr_data = 8'h06;
    @(negedge clk);
    cpu_wr_odd = 1; cpu_wr_data = 8'h0B;
    prg_win = 2'd0; #0.2;
    check("R2", "before edge", int'(prg_bank), 0);
    @(negedge clk);
    cpu_wr = 0;
    model_write(3'b100, 0, 8'h06); model_write(3'b100, 1, 8'h0B);
    check_all("R3 reg6 load");

    // R5: high bits discarded
    set_reg(4'd7, 8'hFD, 3'b000);   check_all("R5 mask prg");
    set_reg(4'd15, 8'h24, 3'b000);  check_all("R3 reg15");
    set_reg(4'd2, 8'hF3, 3'b000);   check_all("R5 mask chr");
    // R4 swap
    wr(3'b100, 1'b0, 8'h40);        check_all("R4 swap");
    // R2 ignored indices
    for (int i = 10; i < 15; i++) begin
      wr(3'b100, 1'b0, 8'(i));
      wr(3'b100, 1'b1, 8'hAA);
      check_all("R2 ignored index");
    end
    // R7 pairs with odd register values, R8 full mode
    set_reg(4'd0, 8'h13, 3'b000);   set_reg(4'd1, 8'h2A, 3'b000);
    set_reg(4'd8, 8'h55, 3'b000);   set_reg(4'd9, 8'h66, 3'b000);
    check_all("R7 pairs");
    wr(3'b100, 1'b0, 8'h20);        check_all("R8 full 1k");
    // R6 half invert, with and without full mode
    wr(3'b100, 1'b0, 8'hA0);        check_all("R6 invert full");
    wr(3'b100, 1'b0, 8'h80);        check_all("R6 invert pairs");
    set_reg(4'd3, 8'h31, 3'b100);   set_reg(4'd4, 8'h42, 3'b100);
    set_reg(4'd5, 8'h7F, 3'b100);   check_all("R9 upper slots");
    // R10 mirroring
    wr(3'b101, 1'b0, 8'h01);        check_all("R10 horizontal");
    wr(3'b101, 1'b1, 8'h00);        check_all("R10 odd ignored");
    wr(3'b101, 1'b0, 8'hFE);        check_all("R10 vertical");
    // R12 other pages
    wr(3'b110, 1'b0, 8'hFF); wr(3'b111, 1'b1, 8'hFF); wr(3'b000, 1'b1, 8'hFF);
    check_all("R12 other pages");

    // Constrained random, biased toward the bank page
    for (int n = 0; n < 1500; n++) begin
      logic [2:0] pg;
      int r;
      r = int'($urandom_range(0, 9));
      pg = (r < 6) ? 3'b100 : (r < 8) ? 3'b101 : 3'($urandom_range(0, 7));
      wr(pg, 1'($urandom_range(0, 1)), 8'($urandom));
      check_all("R1 R2 random");
    end

    // R11 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    model_reset();
    @(negedge clk);
    check_all("R11 rereset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule